// File: doc/BRIEF.md
# NVM Readiness Poll Sequencer

This block is a small control state machine that sits above a byte-wide serial PHY. It finds out, through the PHY, when a target's non-volatile memory can be used. The host gives a one-cycle start pulse and a mode bit, and the sequencer then runs one of two polls.

In bus-enable mode (mode = 0), the sequencer sends one command byte. That byte is a control/status-load opcode merged with a status register index. The sequencer then waits for one reply byte. It repeats this pair until a reply shows the NVM-enabled flag, or until a fixed number of attempts has failed.

In controller-busy mode (mode = 1), the sequencer sends a direct-load opcode that carries a one-byte data-size code, followed by a four-byte address of the NVM controller's status byte. It keeps polling, with no attempt limit, until bit 7 of the reply is clear.

Each poll ends with a one-cycle done pulse. The pulse carries either ok or timeout. All opcodes, the register index, the flag position, the register base address and the attempt limit are parameters.

Top module: `nvm_poll_seq`

## Requirements
- R1: After a synchronous reset, busy, tx_valid, rx_en, done, ok and timeout are all 0.
- R2: A start pulse with mode = 0 makes the sequencer present one byte on tx_data, the value CS_LOAD_OP | STATUS_REG_IDX (0x80 with the defaults). Once that byte is accepted, rx_en is asserted to wait for the reply.
- R3: In mode 0, a reply with bit NVM_FLAG_BIT set (bit 1 by default) ends the poll with done = 1, ok = 1 and timeout = 0.
- R4: In mode 0, after MAX_TRIES consecutive replies without the flag (255 by default), the poll ends with done = 1, timeout = 1 and ok = 0. Exactly MAX_TRIES command bytes are sent in that case.
- R5: In mode 1, each attempt sends five bytes. The first is DIRECT_LOAD_OP | (SIZE_1B_CODE << 2) (0x00 with the defaults). The other four are the address NVM_REG_BASE + STATUS_OFFSET (0x010001CF by default), least significant byte first. rx_en rises only after the fifth byte is accepted.
- R6: In mode 1, the attempt repeats while bit 7 of the reply is 1, with no attempt limit. The first reply with bit 7 = 0 ends the poll with ok = 1. Timeout is never raised in this mode.
- R7: A byte on tx_data stays stable, with tx_valid high, until the cycle in which tx_ready is high. The next byte appears only after that handshake.
- R8: A start pulse while busy = 1 has no effect. This includes a start that carries the other mode. The running poll continues unchanged.
- R9: done is high for exactly one cycle per poll. ok and timeout are high only while done is high, and exactly one of them is set. busy is 0 in the done cycle.
- R10: A reply pulse on rx_valid while the sequencer is sending (rx_en = 0) is ignored. It neither ends nor shortens the current attempt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a poll |
| mode | input | 1 | 0 = bounded bus-enable poll, 1 = unbounded controller-busy poll |
| tx_data | output | 8 | Byte offered to the PHY transmitter |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | PHY accepts tx_data in this cycle |
| rx_en | output | 1 | Sequencer is waiting for a reply byte |
| rx_data | input | 8 | Reply byte from the PHY |
| rx_valid | input | 1 | rx_data holds a received byte |
| busy | output | 1 | A poll is in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | With done: readiness condition was seen |
| timeout | output | 1 | With done: attempt limit reached |

## Verification
The in-RTL assertions check the cycle-level contracts on every clock. These are: the transmit byte is held stable until it is accepted, done is a single-cycle pulse, ok and timeout appear only with done and never together, timeout never appears in the unbounded mode, the latched mode does not change mid-poll, and the attempt counter stays bounded. The bench scenarios show the rest. They cover the exact byte sequences and address ordering, the number of attempts before success or timeout (including success on the very last allowed attempt), polls longer than the attempt limit in the unbounded mode, and that a start or a stray reply arriving during a poll leaves it untouched.

// File: rtl/nvm_poll_pkg.sv
package nvm_poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    typedef enum logic {
        POLL_BUS_EN     = 1'b0,
        POLL_CTRL_BUSY  = 1'b1
    } poll_mode_e;

    typedef struct packed {
        logic ok;
        logic timeout;
    } poll_result_t;

    localparam int unsigned ADDR_BYTES   = 4;
    localparam int unsigned BUSY_BIT     = 7;
    localparam int unsigned IDX_W        = 3;

    // reply is "good" when it shows the readiness condition for the mode
    function automatic logic reply_good(input poll_mode_e m,
                                        input logic [7:0] rx,
                                        input int unsigned flag_bit);
        if (m == POLL_BUS_EN)
            return rx[flag_bit];
        else
            return ~rx[BUSY_BIT];
    endfunction

endpackage

// File: rtl/nvm_poll_txsel.sv
module nvm_poll_txsel
    import nvm_poll_pkg::*;
#(
    parameter logic [7:0]  CS_LOAD_OP     = 8'h80,
    parameter logic [7:0]  STATUS_REG_IDX = 8'h00,
    parameter logic [7:0]  DIRECT_LOAD_OP = 8'h00,
    parameter logic [1:0]  SIZE_1B_CODE   = 2'b00,
    parameter logic [31:0] NVM_REG_BASE   = 32'h0100_01C0,
    parameter logic [7:0]  STATUS_OFFSET  = 8'h0F
) (
    input  poll_mode_e        mode,
    input  logic [IDX_W-1:0]  idx,
    output logic [7:0]        tx_byte,
    output logic              last
);
    localparam logic [31:0] TARGET_ADDR = NVM_REG_BASE + {24'h0, STATUS_OFFSET};
    localparam logic [7:0]  BUS_CMD     = CS_LOAD_OP | STATUS_REG_IDX;
    localparam logic [7:0]  BUSY_CMD    = DIRECT_LOAD_OP | {4'b0000, SIZE_1B_CODE, 2'b00};

    logic [7:0] addr_b [ADDR_BYTES];

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
        assign addr_b[g] = TARGET_ADDR[8*g +: 8];
    end

    always_comb begin
        if (mode == POLL_BUS_EN)
            last = (idx == '0);
        else
            last = (idx == IDX_W'(ADDR_BYTES));

        if (idx == '0)
            tx_byte = (mode == POLL_BUS_EN) ? BUS_CMD : BUSY_CMD;
        else
            tx_byte = addr_b[2'(idx - IDX_W'(1))];
    end
endmodule

// File: rtl/nvm_poll_tries.sv
module nvm_poll_tries #(
    parameter int unsigned LIMIT = 255
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] count_q;

    assign exhausted = (count_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            count_q <= '0;
        else if (inc && !exhausted)
            count_q <= count_q + CW'(1);
    end

    // R4: attempt count never passes the limit
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
        count_q < CW'(LIMIT));
endmodule

// File: rtl/nvm_poll_seq.sv
module nvm_poll_seq
    import nvm_poll_pkg::*;
#(
    parameter logic [7:0]  CS_LOAD_OP     = 8'h80,
    parameter logic [7:0]  STATUS_REG_IDX = 8'h00,
    parameter int unsigned NVM_FLAG_BIT   = 1,
    parameter logic [7:0]  DIRECT_LOAD_OP = 8'h00,
    parameter logic [1:0]  SIZE_1B_CODE   = 2'b00,
    parameter logic [31:0] NVM_REG_BASE   = 32'h0100_01C0,
    parameter logic [7:0]  STATUS_OFFSET  = 8'h0F,
    parameter int unsigned MAX_TRIES      = 255
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       mode,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic       rx_en,
    input  logic [7:0] rx_data,
    input  logic       rx_valid,
    output logic       busy,
    output logic       done,
    output logic       ok,
    output logic       timeout
);
    seq_state_e         state_q;
    poll_mode_e         mode_q;
    logic [IDX_W-1:0]   idx_q;
    logic               done_q;
    poll_result_t       res_q;

    logic last_byte, exhausted, tx_fire, rx_fire, good, launch, miss;

    nvm_poll_txsel #(
        .CS_LOAD_OP     (CS_LOAD_OP),
        .STATUS_REG_IDX (STATUS_REG_IDX),
        .DIRECT_LOAD_OP (DIRECT_LOAD_OP),
        .SIZE_1B_CODE   (SIZE_1B_CODE),
        .NVM_REG_BASE   (NVM_REG_BASE),
        .STATUS_OFFSET  (STATUS_OFFSET)
    ) i_txsel (
        .mode    (mode_q),
        .idx     (idx_q),
        .tx_byte (tx_data),
        .last    (last_byte)
    );

    assign tx_valid = (state_q == ST_SEND);
    assign rx_en    = (state_q == ST_WAIT);
    assign busy     = (state_q != ST_IDLE);
    assign tx_fire  = tx_valid && tx_ready;
    assign rx_fire  = rx_en && rx_valid;
    assign launch   = (state_q == ST_IDLE) && start;
    assign good     = reply_good(mode_q, rx_data, NVM_FLAG_BIT);
    assign miss     = rx_fire && !good && (mode_q == POLL_BUS_EN);

    nvm_poll_tries #(.LIMIT(MAX_TRIES)) i_tries (
        .clk       (clk),
        .rst       (rst),
        .clr       (launch),
        .inc       (miss),
        .exhausted (exhausted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= POLL_BUS_EN;
            idx_q   <= '0;
            done_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            done_q <= 1'b0;
            res_q  <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q  <= poll_mode_e'(mode);
                        idx_q   <= '0;
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tx_fire) begin
                        if (last_byte) begin
                            idx_q   <= '0;
                            state_q <= ST_WAIT;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                ST_WAIT: begin
                    if (rx_fire) begin
                        if (good) begin
                            done_q   <= 1'b1;
                            res_q.ok <= 1'b1;
                            state_q  <= ST_IDLE;
                        end else if (mode_q == POLL_BUS_EN && exhausted) begin
                            done_q        <= 1'b1;
                            res_q.timeout <= 1'b1;
                            state_q       <= ST_IDLE;
                        end else begin
                            state_q <= ST_SEND;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done    = done_q;
    assign ok      = res_q.ok;
    assign timeout = res_q.timeout;

    // R7: offered byte held until accepted
    a_r7_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R9: single-cycle completion pulse, result only with it
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_result_gated: assert property (@(posedge clk) disable iff (rst)
        (ok || timeout) |-> done);
    a_r9_one_result: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones({ok, timeout}) == 1 && !busy));

    // R6: unbounded mode never times out
    a_r6_no_timeout: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (mode_q == POLL_BUS_EN));

    // R8: latched mode is frozen while a poll runs
    a_r8_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(mode_q)));

    // R5: byte index stays inside the five-byte frame
    a_r5_idx_range: assert property (@(posedge clk) disable iff (rst)
        idx_q <= IDX_W'(ADDR_BYTES));
endmodule

// File: tb/test_nvm_poll_seq.sv
module test_nvm_poll_seq;
    localparam int          MAXT      = 255;
    localparam int          FLAG      = 1;
    localparam logic [31:0] ADDR      = 32'h0100_01C0 + 32'h0F;
    localparam logic [7:0]  BUS_CMD   = 8'h80 | 8'h00;
    localparam logic [7:0]  BUSY_CMD  = 8'h00 | (8'h00 << 2);

    logic clk = 0, rst = 1, start = 0, mode = 0;
    logic [7:0] tx_data, rx_data = 0;
    logic tx_valid, tx_ready = 0, rx_en, rx_valid = 0;
    logic busy, done, ok, timeout;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    nvm_poll_seq i_nvm_poll_seq (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_en(rx_en), .rx_data(rx_data), .rx_valid(rx_valid),
        .busy(busy), .done(done), .ok(ok), .timeout(timeout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input bit m, input int i);
        if (i == 0) return m ? BUSY_CMD : BUS_CMD;
        return ADDR[8*(i-1) +: 8];
    endfunction

    function automatic logic [7:0] reply(input bit m, input int n, input bit good);
        logic [7:0] v = 8'(n * 37 + 5);
        if (!m) return good ? (v | 8'(1 << FLAG)) : (v & ~8'(1 << FLAG));
        return good ? (v & 8'h7F) : (v | 8'h80);
    endfunction

    task automatic run_poll(input bit m, input int n_bad, input int dly,
                            input bit poke, input bit stray);
        int idx = 0, resp = 0, wc = 0, cyc = 0;
        int frame = m ? 5 : 1;
        int attempts;
        bit exp_to, fin = 0;
        exp_to   = (!m && n_bad >= MAXT);
        attempts = exp_to ? MAXT : n_bad + 1;
        @(negedge clk);
        start = 1; mode = m;
        @(negedge clk);
        start = 0;
        while (!fin) begin
            tx_ready = 0; rx_valid = 0; start = 0;
            if (done) begin
                fin = 1;
                chk(exp_to ? "R4 timeout" : (m ? "R6 ok" : "R3 ok"), ok, !exp_to);
                chk(exp_to ? "R4 timeout flag" : "R9 timeout flag", timeout, exp_to);
                chk(m ? "R6 attempts" : "R4 attempts", resp, attempts);
                chk("R9 busy at done", busy, 0);
            end else begin
                if (poke) begin start = 1; mode = ~m; end
                if (tx_valid) begin
                    chk(m ? "R5 tx byte" : "R2 tx byte", tx_data, exp_byte(m, idx));
                    if (wc >= dly) begin
                        tx_ready = 1; idx++; wc = 0;
                    end else begin
                        wc++;
                        if (stray) begin rx_valid = 1; rx_data = reply(m, 99, 1); end
                    end
                end else if (rx_en) begin
                    chk(m ? "R5 frame length" : "R2 frame length", idx, frame);
                    if (wc >= dly) begin
                        rx_valid = 1;
                        rx_data  = reply(m, resp, resp >= n_bad);
                        resp++; idx = 0; wc = 0;
                    end else wc++;
                end
            end
            cyc++;
            if (cyc > 40000) begin
                fails++;
                $display("FAIL R9 poll never completed: actual 0 expected 1");
                fin = 1;
            end
            @(negedge clk);
        end
        start = 0; tx_ready = 0; rx_valid = 0;
        chk("R9 done one cycle", done, 0);
        chk("R9 idle after done", {busy, tx_valid, rx_en}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 reset outputs", {busy, tx_valid, rx_en, done, ok, timeout}, 0);
        // bounded poll, success at various attempts and handshake delays
        for (int d = 0; d < 3; d++)
            for (int n = 0; n < 4; n++)
                run_poll(0, n, d, 0, 0);
        run_poll(0, MAXT - 1, 0, 0, 0);   // success on last allowed attempt
        run_poll(0, MAXT, 0, 0, 0);       // R4 exactly at limit
        run_poll(0, MAXT + 40, 1, 0, 0);  // R4 more misses available than limit
        // unbounded poll
        for (int d = 0; d < 2; d++)
            for (int n = 0; n < 4; n++)
                run_poll(1, n, d, 0, 0);
        run_poll(1, MAXT + 45, 0, 0, 0);  // R6 beyond the bounded limit
        // R8 start while busy, R10 stray replies during transmit
        run_poll(0, 3, 1, 1, 0);
        run_poll(1, 2, 1, 1, 0);
        run_poll(0, 2, 2, 0, 1);
        run_poll(1, 3, 2, 0, 1);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual expired expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule